// File: doc/BRIEF.md
# Prescaled Compare-Match Timer

This peripheral holds a 32-bit up-counter, a 32-bit threshold and a small control register. Software reaches all three through a simple synchronous bus port. Once enabled, the counter advances at the system clock divided by one of eight fixed ratios. The counter is compared with the threshold on every advance. A match raises a sticky alarm flag, and a level interrupt output follows that flag.

Two match behaviours are offered:

- **Single-shot:** the counter freezes on the matching value, and no further alarm is raised until software rewrites the counter or the threshold, or disables the timer.
- **Continuous:** the counter returns to zero on the match and keeps counting, so alarms recur with a fixed period.

Software clears the alarm by writing zero to its control bit. Disabling the timer also clears the alarm.

Top module: `match_timer`

## Requirements
- R1: After reset the control, threshold and counter registers read zero and `irq` is low.
- R2: Byte offset 0x0 is control, 0x4 is threshold and 0x8 is counter. Control bit 0 is enable, bits 3:1 are the divide select, bit 4 is mode (0 single-shot, 1 continuous) and bit 5 is the alarm. Threshold and counter read back the value last written.
- R3: Control bits 31:6 read zero. Any other offset reads zero. `busRdata` is zero while `busRe` is low.
- R4: While enabled, the counter advances once every N clock cycles. N is 2, 4, 8, 64, 128, 1024, 2048 or 4096 for select codes 0 through 7. Enabling with counter 0 and threshold T raises `irq` exactly N*(T+1) cycles after the enabling write.
- R5: In single-shot mode the match raises the alarm and the counter holds the threshold value. After software clears the alarm it does not return until the counter or threshold is written or the timer is disabled. A threshold write lets counting resume.
- R6: In continuous mode the match raises the alarm and loads zero into the counter. The next match follows N*(T+1) cycles after the previous one.
- R7: `irq` equals the alarm flag, which stays set until it is cleared. A control write with bit 5 at 0 clears it. A control write with bit 5 at 1 has no effect on it.
- R8: While disabled, the counter holds its value, the alarm is cleared one cycle after enable reads low, and no alarm is raised.
- R9: A bus write to the counter wins over an advance or a match reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Byte offset of the access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read enable |
| busRdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Level interrupt, copy of the alarm flag |

## Verification
A wrong prescaler phase or a wrong ratio shows up as an `irq` edge that arrives too early or too late. For every select code the delay is compared cycle-exactly with N*(T+1), so one lost or extra cycle is caught at the first alarm. A broken halt flag or a broken reload shows up in the counter readback just after the alarm. A halt flag that is stuck shows as an `irq` that re-pends within a few dozen cycles of being cleared. Write-priority faults show in the counter readback one cycle after a write that collides with an advance.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic tick;
    logic wrCount;
    logic wrThres;
    logic contMode;
    logic enable;
  } tmrStrobe_t;

  // log2 of the divide ratio for each select code
  function automatic int unsigned ratioShift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0: ratioShift = 1;
      3'd1: ratioShift = 2;
      3'd2: ratioShift = 3;
      3'd3: ratioShift = 6;
      3'd4: ratioShift = 7;
      3'd5: ratioShift = 10;
      3'd6: ratioShift = 11;
      default: ratioShift = 12;
    endcase
  endfunction
endpackage

// File: rtl/match_timer_ctrl.sv
module match_timer_ctrl
  import match_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int PSC_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [5:0]        ctrlWdata,
  input  logic              busRe,
  input  logic [DATA_W-1:0] countVal,
  input  logic [DATA_W-1:0] thresVal,
  input  logic              hit,
  output tmrStrobe_t        strobe,
  output logic              alarm,
  output logic [DATA_W-1:0] busRdata
);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_THRES = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_COUNT = ADDR_W'(8);

  logic             enReg;
  logic             modeReg;
  logic [SEL_W-1:0] selReg;
  logic [PSC_W-1:0] pscCnt;
  logic [PSC_W-1:0] pscLimit;
  logic             wrCtrl;
  logic             tick;

  assign wrCtrl   = busWe && (busAddr == OFS_CTRL);
  assign pscLimit = PSC_W'((1 << ratioShift(selReg)) - 1);
  assign tick     = enReg && (pscCnt >= pscLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      modeReg <= 1'b0;
      selReg  <= '0;
    end else if (wrCtrl) begin
      enReg   <= ctrlWdata[0];
      selReg  <= ctrlWdata[3:1];
      modeReg <= ctrlWdata[4];
    end
  end

  // a hardware match wins over a same-cycle software clear
  always_ff @(posedge clk) begin
    if (!rstN || !enReg)           alarm <= 1'b0;
    else if (hit)                  alarm <= 1'b1;
    else if (wrCtrl && !ctrlWdata[5]) alarm <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enReg) pscCnt <= '0;
    else if (tick)       pscCnt <= '0;
    else                 pscCnt <= pscCnt + PSC_W'(1);
  end

  always_comb begin
    strobe.tick     = tick;
    strobe.wrCount  = busWe && (busAddr == OFS_COUNT);
    strobe.wrThres  = busWe && (busAddr == OFS_THRES);
    strobe.contMode = modeReg;
    strobe.enable   = enReg;
  end

  always_comb begin
    busRdata = '0;
    if (busRe) begin
      case (busAddr)
        OFS_CTRL: begin
          busRdata[0]   = enReg;
          busRdata[3:1] = selReg;
          busRdata[4]   = modeReg;
          busRdata[5]   = alarm;
        end
        OFS_THRES: busRdata = thresVal;
        OFS_COUNT: busRdata = countVal;
        default:   busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/match_timer_dp.sv
module match_timer_dp
  import match_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] thresVal,
  output logic              hit
);
  logic doneReg;
  logic halted;
  logic match;
  logic advance;

  assign halted  = doneReg && !strobe.contMode;
  assign match   = (countVal == thresVal);
  assign advance = strobe.tick && !halted;
  assign hit     = advance && match;

  always_ff @(posedge clk) begin
    if (!rstN)               countVal <= '0;
    else if (strobe.wrCount) countVal <= busWdata;
    else if (advance) begin
      if (!match)               countVal <= countVal + DATA_W'(1);
      else if (strobe.contMode) countVal <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               thresVal <= '0;
    else if (strobe.wrThres) thresVal <= busWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.enable || strobe.wrCount || strobe.wrThres || strobe.contMode)
      doneReg <= 1'b0;
    else if (hit)
      doneReg <= 1'b1;
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int PSC_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  tmrStrobe_t        strb;
  logic [DATA_W-1:0] countVal;
  logic [DATA_W-1:0] thresVal;
  logic              hit;
  logic              alarm;

  match_timer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PSC_W(PSC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .ctrlWdata(busWdata[5:0]), .busRe(busRe), .countVal(countVal),
    .thresVal(thresVal), .hit(hit), .strobe(strb), .alarm(alarm),
    .busRdata(busRdata)
  );

  match_timer_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strb), .busWdata(busWdata),
    .countVal(countVal), .thresVal(thresVal), .hit(hit)
  );

  assign irq = alarm;
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic              busRe,
  input logic [DATA_W-1:0] busRdata,
  input logic              irq,
  input logic              en,
  input logic              mode,
  input logic              tick,
  input logic              wrCount,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] thres
);
  logic clearWr;
  assign clearWr = busWe && (busAddr == ADDR_W'(0)) && !busWdata[5];

  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr != ADDR_W'(0) && busAddr != ADDR_W'(4) && busAddr != ADDR_W'(8))
      |-> busRdata == '0);

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    (en && !wrCount && count != thres)
      |=> (count == $past(count) || count == $past(count) + DATA_W'(1)));

  p_single_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (en && !mode && count == thres && !wrCount) |=> $stable(count));

  p_cont_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && mode && count == thres && !wrCount) |=> count == '0);

  p_alarm_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irq && en && !clearWr) |=> irq);

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !irq);

  p_disable_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !wrCount) |=> $stable(count));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(8)) |=> count == $past(busWdata));
endmodule

bind match_timer match_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
  .busRe(busRe), .busRdata(busRdata), .irq(irq), .en(strb.enable),
  .mode(strb.contMode), .tick(strb.tick), .wrCount(strb.wrCount),
  .count(countVal), .thres(thresVal)
);

// File: tb/sim_match_timer.sv
module sim_match_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  match_timer u0 (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata), .irq(irq));

  always #5ns clk = ~clk;

  // {mode, sel, thres}
  localparam logic [35:0] VECS [0:7] = '{
    {1'b0, 3'd0, 32'd3}, {1'b1, 3'd1, 32'd2}, {1'b0, 3'd2, 32'd5},
    {1'b1, 3'd3, 32'd1}, {1'b0, 3'd4, 32'd2}, {1'b1, 3'd5, 32'd0},
    {1'b0, 3'd6, 32'd1}, {1'b1, 3'd7, 32'd2}};

  function automatic int ratioOf(input int sel);
    case (sel)
      0: return 2;    1: return 4;    2: return 8;    3: return 64;
      4: return 128;  5: return 1024; 6: return 2048; default: return 4096;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    busRe = 1'b1; busAddr = a;
    #1ns;
    d = busRdata;
    busRe = 1'b0;
  endtask

  task automatic waitIrq(input int limit, output int n);
    n = 0;
    while (!irq && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #2000000ns;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    peek(4'h0, d); check("R1 ctrl", d, 0);
    peek(4'h4, d); check("R1 thres", d, 0);
    peek(4'h8, d); check("R1 count", d, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // R2 / R3 register map
    wr(4'h4, 32'hA5A5_1234);
    peek(4'h4, d); check("R2 thres readback", d, 32'hA5A5_1234);
    wr(4'h0, 32'hFFFF_FFFE);
    peek(4'h0, d); check("R3 ctrl upper bits zero, R7 alarm not set", d, 32'h0000_001E);
    wr(4'h0, 32'h0);
    wr(4'h8, 32'h1234_5678);
    peek(4'h8, d); check("R2 count readback", d, 32'h1234_5678);
    peek(4'hC, d); check("R3 unmapped 0xC", d, 0);
    peek(4'h2, d); check("R3 unmapped 0x2", d, 0);
    busAddr = 4'h8; #1ns; check("R3 read enable low", busRdata, 0);
    @(negedge clk);

    // R8 counter frozen while disabled
    repeat (20) @(negedge clk);
    peek(4'h8, d); check("R8 count held while disabled", d, 32'h1234_5678);

    // R4 / R5 / R6 vector walk
    for (int i = 0; i < 8; i++) begin
      int r;
      int t;
      r = ratioOf(int'(VECS[i][34:32]));
      t = int'(VECS[i][31:0]);
      wr(4'h0, 32'h0);
      wr(4'h8, 32'h0);
      wr(4'h4, VECS[i][31:0]);
      wr(4'h0, {27'd0, VECS[i][35], VECS[i][34:32], 1'b1});
      waitIrq(r * (t + 1) + 10, n);
      check($sformatf("R4 alarm delay sel %0d", i), n, r * (t + 1));
      peek(4'h8, d);
      if (VECS[i][35]) check($sformatf("R6 count reloaded sel %0d", i), d, 0);
      else             check($sformatf("R5 count holds sel %0d", i), d, t);
    end

    // R6 / R7 continuous, ratio 2, threshold 3
    wr(4'h0, 32'h0);
    wr(4'h8, 32'h0);
    wr(4'h4, 32'd3);
    wr(4'h0, 32'h11);
    waitIrq(40, n);
    check("R6 first alarm", n, 8);
    repeat (2) @(negedge clk);
    check("R7 alarm sticky", {31'd0, irq}, 1);
    wr(4'h0, 32'h31);
    check("R7 writing one keeps alarm", {31'd0, irq}, 1);
    wr(4'h0, 32'h11);
    check("R7 writing zero clears alarm", {31'd0, irq}, 0);
    waitIrq(40, n);
    check("R6 period between alarms", n, 4);

    // R5 single-shot, ratio 2, threshold 2
    wr(4'h0, 32'h0);
    wr(4'h8, 32'h0);
    wr(4'h4, 32'd2);
    wr(4'h0, 32'h01);
    waitIrq(40, n);
    check("R5 single-shot alarm", n, 6);
    wr(4'h0, 32'h01);
    check("R5 alarm cleared", {31'd0, irq}, 0);
    repeat (30) @(negedge clk);
    check("R5 no re-pend after stop", {31'd0, irq}, 0);
    peek(4'h8, d); check("R5 count stays at threshold", d, 2);
    wr(4'h4, 32'd4);
    waitIrq(40, n);
    check("R5 resumes after threshold write", {31'd0, irq}, 1);
    peek(4'h8, d); check("R5 count at new threshold", d, 4);

    // R8 disable clears alarm and holds count
    wr(4'h0, 32'h0);
    @(negedge clk);
    check("R8 disable clears alarm", {31'd0, irq}, 0);
    repeat (20) @(negedge clk);
    peek(4'h8, d); check("R8 count kept after disable", d, 4);
    check("R8 no alarm while disabled", {31'd0, irq}, 0);

    // R9 counter write wins over an advance
    wr(4'h4, 32'd1000);
    wr(4'h8, 32'd0);
    wr(4'h0, 32'h11);
    for (int off = 0; off < 2; off++) begin
      repeat (off + 3) @(negedge clk);
      busWe = 1'b1; busAddr = 4'h8; busWdata = 32'd50;
      @(negedge clk);
      @(negedge clk);
      busWe = 1'b0;
      peek(4'h8, d); check($sformatf("R9 write priority phase %0d", off), d, 50);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule